// File: doc/BRIEF.md
# USB Buffer Descriptor Write-Back Engine

This block sits between a USB serial interface engine and the RAM that holds the endpoint buffer descriptor table. For every finished IN, OUT or SETUP transaction, the serial engine raises a one-cycle request. The request carries the descriptor index, the token PID and the transfer kind.

The engine then works through the transaction in four steps:

- It fetches the descriptor's four bytes.
- It checks that the serial engine currently owns the descriptor.
- For OUT and SETUP data, it streams the received bytes into the endpoint buffer while enforcing the byte limit held in the descriptor.
- It returns an ACK or NAK decision. On success it writes back the actual 10-bit byte count, the token PID and a cleared ownership bit.

Each descriptor occupies four consecutive bytes in the table. The status byte holds the ownership flag in bit 7. On write-back, status bits 5:2 hold the PID and bits 1:0 hold count bits 9:8. The count byte holds count bits 7:0. Two further bytes hold the buffer start address, low byte first.

The engine handles one transaction at a time. It reports that it is occupied through a busy flag.

Top module: `usb_bd_writeback`

## Requirements
- R1: While and right after reset, `busy_o`, `hs_valid_o`, `done_o` and `ram_we_o` are low.
- R2: A request sampled while idle makes `busy_o` high from the next cycle. A request sampled while busy is ignored and does not alter the descriptor it names.
- R3: Descriptor n lives at byte addresses BD_BASE+4n+0 (status), +1 (count bits 7:0), +2 (start address low) and +3 (start address high). RAM reads return data one cycle after the address.
- R4: If status bit 7 (ownership) is 0 when the descriptor is read, the block answers NAK (`hs_valid_o`=1, `hs_ack_o`=0). It writes nothing to RAM and gives no `done_o`.
- R5: For kind OUT (0) or SETUP (2), the k-th received byte (k from 0) is written to address start+k. Here start is the 16-bit descriptor address truncated to the RAM width, with no range check or correction. Bytes are taken on the sixth and later rising edges after the request edge, until `rx_eop_i`, which carries no data.
- R6: The limit is the 10-bit count read from status bits 1:0 and the count byte. If an OUT/SETUP packet carries more bytes than the limit, the answer is NAK, bytes past the limit are not written, and the status and count bytes stay unchanged. A packet of exactly the limit is accepted.
- R7: A successful OUT/SETUP writes the received count bits 7:0 to the count byte. It also writes status = {0, 0, PID[3:0], count[9:8]}, which clears ownership, and answers ACK.
- R8: For kind IN (1), nothing is received. The stored count is written back unchanged as the number of bytes sent, the status is written as in R7, and the answer is ACK.
- R9: `done_o` is a one-cycle pulse given only together with an ACK, with `done_idx_o` equal to the request's index.
- R10: `busy_o` stays high up to and including the handshake cycle and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request strobe |
| req_idx_i | input | $clog2(NUM_BD) | Descriptor index |
| req_pid_i | input | 4 | Token PID |
| req_kind_i | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_eop_i | input | 1 | End of received packet |
| ram_addr_o | output | AW | RAM byte address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after address |
| busy_o | output | 1 | Transaction in progress |
| hs_valid_o | output | 1 | Handshake decision valid |
| hs_ack_o | output | 1 | 1 ACK, 0 NAK |
| done_o | output | 1 | Transaction completed pulse |
| done_idx_o | output | $clog2(NUM_BD) | Index of completed descriptor |

## Verification
The bench goes after these corner cases, each paired with the fault it would expose:

- A packet of exactly the limit. An off-by-one limit compare would turn it into a NAK.
- A packet two bytes over the limit. A design that updated the count anyway would corrupt the descriptor, and one that kept writing would overrun the buffer.
- A zero-length packet against a zero limit.
- A count above 255. Dropping or misplacing bits 9:8 would show up in the status byte.
- A descriptor the CPU still owns. A design that skipped the ownership test would write back or pulse done.
- A start address outside the usual buffer window. A design that "corrected" it would land the data elsewhere.
- A second request raised mid-transaction. If it were accepted, the wrong index would be reported or the second descriptor would be rewritten.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 10;
  localparam int unsigned PID_W  = 4;

  localparam logic [1:0] KIND_OUT   = 2'd0;
  localparam logic [1:0] KIND_IN    = 2'd1;
  localparam logic [1:0] KIND_SETUP = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_CNT,
    ST_RD_ALO,
    ST_RD_AHI,
    ST_RD_LAST,
    ST_DATA,
    ST_WR_CNT,
    ST_WR_STAT,
    ST_ACK,
    ST_NAK
  } bd_state_e;
endpackage

// File: rtl/usb_bd_ctrl.sv
module usb_bd_ctrl
  import usb_bd_pkg::*;
#(
  parameter int unsigned IDXW = 6,
  parameter int unsigned AW   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [IDXW-1:0]   req_idx_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              rx_eop_i,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  input  logic              ovf_i,
  output bd_state_e         state_o,
  output logic [IDXW-1:0]   idx_o,
  output logic [PID_W-1:0]  pid_o,
  output logic              is_in_o,
  output logic [CNT_W-1:0]  max_o,
  output logic [AW-1:0]     start_o
);
  bd_state_e         state_q;
  logic [IDXW-1:0]   idx_q;
  logic [PID_W-1:0]  pid_q;
  logic              is_in_q;
  logic              own_q;
  logic [CNT_W-1:0]  max_q;
  logic [BYTE_W-1:0] alo_q;
  logic [AW-1:0]     start_q;

  // status bits 6:2 carry CPU-side settings, not needed here
  logic unused_stat_bits;
  assign unused_stat_bits = ^ram_rdata_i[6:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pid_q   <= '0;
      is_in_q <= 1'b0;
      own_q   <= 1'b0;
      max_q   <= '0;
      alo_q   <= '0;
      start_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          idx_q   <= req_idx_i;
          pid_q   <= req_pid_i;
          is_in_q <= (req_kind_i == KIND_IN);
          state_q <= ST_RD_STAT;
        end
        ST_RD_STAT: state_q <= ST_RD_CNT;
        ST_RD_CNT: begin
          own_q        <= ram_rdata_i[7];
          max_q[9:8]   <= ram_rdata_i[1:0];
          state_q      <= ST_RD_ALO;
        end
        ST_RD_ALO: begin
          max_q[7:0] <= ram_rdata_i;
          state_q    <= ST_RD_AHI;
        end
        ST_RD_AHI: begin
          alo_q   <= ram_rdata_i;
          state_q <= ST_RD_LAST;
        end
        ST_RD_LAST: begin
          start_q <= AW'({ram_rdata_i, alo_q});  // truncated, never validated
          if (!own_q)       state_q <= ST_NAK;
          else if (is_in_q) state_q <= ST_WR_CNT;
          else              state_q <= ST_DATA;
        end
        ST_DATA: if (rx_eop_i) state_q <= ovf_i ? ST_NAK : ST_WR_CNT;
        ST_WR_CNT:  state_q <= ST_WR_STAT;
        ST_WR_STAT: state_q <= ST_ACK;
        ST_ACK:     state_q <= ST_IDLE;
        ST_NAK:     state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign pid_o   = pid_q;
  assign is_in_o = is_in_q;
  assign max_o   = max_q;
  assign start_o = start_q;
endmodule

// File: rtl/usb_bd_rx_limit.sv
module usb_bd_rx_limit
  import usb_bd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             byte_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             store_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             room;

  assign room    = (cnt_q < max_i);
  assign store_o = byte_i && !ovf_q && room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (byte_i && !ovf_q) begin
      if (room) cnt_q <= cnt_q + CNT_W'(1);
      else      ovf_q <= 1'b1;  // sticky until next transaction
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/usb_bd_ram_port.sv
module usb_bd_ram_port
  import usb_bd_pkg::*;
#(
  parameter int unsigned IDXW    = 6,
  parameter int unsigned AW      = 11,
  parameter logic [15:0] BD_BASE = 16'h0000
) (
  input  bd_state_e         state_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [AW-1:0]     start_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              store_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic [CNT_W-1:0]  wb_cnt_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              ram_we_o,
  output logic [BYTE_W-1:0] ram_wdata_o
);
  localparam logic [AW-1:0] BASE = AW'(BD_BASE);

  logic [AW-1:0] row;
  assign row = BASE + AW'({idx_i, 2'b00});

  always_comb begin
    ram_addr_o  = row;
    ram_we_o    = 1'b0;
    ram_wdata_o = '0;
    unique case (state_i)
      ST_RD_CNT: ram_addr_o = row + AW'(1);
      ST_RD_ALO: ram_addr_o = row + AW'(2);
      ST_RD_AHI: ram_addr_o = row + AW'(3);
      ST_DATA: begin
        ram_addr_o  = start_i + AW'(rx_cnt_i);
        ram_we_o    = store_i;
        ram_wdata_o = rx_data_i;
      end
      ST_WR_CNT: begin
        ram_addr_o  = row + AW'(1);
        ram_we_o    = 1'b1;
        ram_wdata_o = wb_cnt_i[7:0];
      end
      ST_WR_STAT: begin
        ram_we_o    = 1'b1;
        ram_wdata_o = {1'b0, 1'b0, pid_i, wb_cnt_i[9:8]};  // ownership handed back
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_bd_writeback.sv
module usb_bd_writeback
  import usb_bd_pkg::*;
#(
  parameter int unsigned NUM_BD  = 64,
  parameter int unsigned AW      = 11,
  parameter logic [15:0] BD_BASE = 16'h0000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic [$clog2(NUM_BD)-1:0] req_idx_i,
  input  logic [3:0]                req_pid_i,
  input  logic [1:0]                req_kind_i,
  input  logic                      rx_valid_i,
  input  logic [7:0]                rx_data_i,
  input  logic                      rx_eop_i,
  output logic [AW-1:0]             ram_addr_o,
  output logic                      ram_we_o,
  output logic [7:0]                ram_wdata_o,
  input  logic [7:0]                ram_rdata_i,
  output logic                      busy_o,
  output logic                      hs_valid_o,
  output logic                      hs_ack_o,
  output logic                      done_o,
  output logic [$clog2(NUM_BD)-1:0] done_idx_o
);
  localparam int unsigned IDXW = $clog2(NUM_BD);

  bd_state_e        state;
  logic [IDXW-1:0]  idx;
  logic [PID_W-1:0] pid;
  logic             is_in;
  logic [CNT_W-1:0] max_cnt;
  logic [AW-1:0]    start;
  logic [CNT_W-1:0] rx_cnt;
  logic             store;
  logic             ovf;
  logic [CNT_W-1:0] wb_cnt;

  usb_bd_ctrl #(.IDXW(IDXW), .AW(AW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_idx_i   (req_idx_i),
    .req_pid_i   (req_pid_i),
    .req_kind_i  (req_kind_i),
    .rx_eop_i    (rx_eop_i),
    .ram_rdata_i (ram_rdata_i),
    .ovf_i       (ovf),
    .state_o     (state),
    .idx_o       (idx),
    .pid_o       (pid),
    .is_in_o     (is_in),
    .max_o       (max_cnt),
    .start_o     (start)
  );

  usb_bd_rx_limit i_limit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state == ST_RD_LAST),
    .byte_i  ((state == ST_DATA) && rx_valid_i),
    .max_i   (max_cnt),
    .cnt_o   (rx_cnt),
    .store_o (store),
    .ovf_o   (ovf)
  );

  // IN reports the stored count as sent; OUT/SETUP report what arrived
  assign wb_cnt = is_in ? max_cnt : rx_cnt;

  usb_bd_ram_port #(.IDXW(IDXW), .AW(AW), .BD_BASE(BD_BASE)) i_ram (
    .state_i     (state),
    .idx_i       (idx),
    .start_i     (start),
    .rx_cnt_i    (rx_cnt),
    .store_i     (store),
    .rx_data_i   (rx_data_i),
    .wb_cnt_i    (wb_cnt),
    .pid_i       (pid),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_wdata_o (ram_wdata_o)
  );

  assign busy_o     = (state != ST_IDLE);
  assign hs_valid_o = (state == ST_ACK) || (state == ST_NAK);
  assign hs_ack_o   = (state == ST_ACK);
  assign done_o     = (state == ST_ACK);
  assign done_idx_o = idx;
endmodule

// File: rtl/usb_bd_wb_chk.sv
module usb_bd_wb_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          rx_valid_i,
  input logic          busy_o,
  input logic          hs_valid_o,
  input logic          hs_ack_o,
  input logic          done_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o,
  input logic [7:0]    ram_wdata_o
);
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);

  assert_we_in_txn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> busy_o);

  assert_nak_no_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o && !hs_ack_o |-> !done_o);

  assert_status_own_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o && !rx_valid_i && (ram_addr_o[1:0] == 2'b00) |-> !ram_wdata_o[7]);

  assert_done_after_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ram_we_o));

  assert_done_with_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hs_valid_o && hs_ack_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hs_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> busy_o);

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |=> !busy_o);
endmodule

bind usb_bd_writeback usb_bd_wb_chk #(.AW(AW)) i_wb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .rx_valid_i  (rx_valid_i),
  .busy_o      (busy_o),
  .hs_valid_o  (hs_valid_o),
  .hs_ack_o    (hs_ack_o),
  .done_o      (done_o),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .ram_wdata_o (ram_wdata_o)
);

// File: tb/test_usb_bd_writeback.sv
module test_usb_bd_writeback;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  typedef struct packed {
    logic [1:0]  kind;
    logic [5:0]  idx;
    logic [3:0]  pid;
    logic        own;
    logic [9:0]  maxc;
    logic [15:0] start;
    logic [10:0] nb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 6'd3,  4'h1, 1'b1, 10'd8,   16'h0400, 11'd5},    // R5 R7 short OUT
    '{2'd1, 6'd10, 4'h9, 1'b1, 10'd677, 16'h0500, 11'd0},    // R8 IN, count > 255
    '{2'd2, 6'd0,  4'hD, 1'b1, 10'd8,   16'h0480, 11'd8},    // R6 exact limit SETUP
    '{2'd0, 6'd63, 4'h1, 1'b1, 10'd4,   16'h0600, 11'd6},    // R6 oversize
    '{2'd0, 6'd20, 4'h1, 1'b0, 10'd16,  16'h0640, 11'd3},    // R4 not owned
    '{2'd0, 6'd33, 4'h1, 1'b1, 10'd300, 16'hF910, 11'd260},  // R5 R7 odd address, count > 255
    '{2'd0, 6'd5,  4'h1, 1'b1, 10'd0,   16'h0700, 11'd0},    // R7 zero length
    '{2'd1, 6'd7,  4'h9, 1'b0, 10'd12,  16'h0720, 11'd0}     // R4 IN not owned
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [5:0] req_idx = '0;
  logic [3:0] req_pid = '0;
  logic [1:0] req_kind = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_eop = 1'b0;
  logic [AW-1:0] ram_addr;
  logic ram_we;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;
  logic busy, hs_valid, hs_ack, done;
  logic [5:0] done_idx;

  logic [7:0] mem [2048];
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  usb_bd_writeback i_usb_bd_writeback (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_idx_i(req_idx),
    .req_pid_i(req_pid), .req_kind_i(req_kind), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_eop_i(rx_eop), .ram_addr_o(ram_addr),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .busy_o(busy), .hs_valid_o(hs_valid), .hs_ack_o(hs_ack),
    .done_o(done), .done_idx_o(done_idx)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [5:0] idx, input int k);
    return 8'(int'(idx) * 7 + k * 3 + 1);
  endfunction

  task automatic setup_bd(input vec_t v);
    logic [10:0] row;
    row = {3'b000, v.idx, 2'b00};
    mem[row]      = {v.own, 5'b01011, v.maxc[9:8]};
    mem[row + 1]  = v.maxc[7:0];
    mem[row + 2]  = v.start[7:0];
    mem[row + 3]  = v.start[15:8];
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    req = 1'b1; req_idx = v.idx; req_pid = v.pid; req_kind = v.kind;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_hs;
    for (int w = 0; w < 5000 && !hs_valid; w++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    logic [10:0] row, bufa;
    logic [7:0] stat0, cnt0;
    int lim, exp_cnt;
    logic exp_ack;
    row = {3'b000, v.idx, 2'b00};
    bufa = v.start[10:0];
    lim = (int'(v.nb) < int'(v.maxc)) ? int'(v.nb) : int'(v.maxc);
    setup_bd(v);
    stat0 = mem[row];
    cnt0  = mem[row + 1];
    for (int k = 0; k <= lim; k++) mem[11'(bufa + 11'(k))] = 8'hEE;
    exp_ack = v.own && (v.kind == 2'd1 || int'(v.nb) <= int'(v.maxc));
    exp_cnt = (v.kind == 2'd1) ? int'(v.maxc) : int'(v.nb);

    issue(v);
    chk("R2", "busy after request", int'(busy), 1);
    repeat (5) @(negedge clk);
    if (v.kind != 2'd1 && v.own) begin
      for (int k = 0; k < int'(v.nb); k++) begin
        rx_valid = 1'b1; rx_data = pat(v.idx, k);
        @(negedge clk);
        if (k % 3 == 2) begin
          rx_valid = 1'b0;
          @(negedge clk);
        end
      end
      rx_valid = 1'b0; rx_eop = 1'b1;
      @(negedge clk);
      rx_eop = 1'b0;
    end
    wait_hs;
    chk("R4/R6", "handshake valid", int'(hs_valid), 1);
    chk(v.own ? "R6/R7/R8" : "R4", "ack", int'(hs_ack), int'(exp_ack));
    chk("R9", "done with ack", int'(done), int'(exp_ack));
    if (exp_ack) chk("R9", "done index", int'(done_idx), int'(v.idx));
    chk("R10", "busy in handshake", int'(busy), 1);
    @(negedge clk);
    chk("R10", "busy after handshake", int'(busy), 0);
    chk("R9", "done one cycle", int'(done), 0);

    if (exp_ack) begin
      chk(v.kind == 2'd1 ? "R8" : "R7", "count byte", int'(mem[row + 1]), exp_cnt & 255);
      chk(v.kind == 2'd1 ? "R8" : "R7", "status byte", int'(mem[row]),
          int'({2'b00, v.pid, 2'(exp_cnt >> 8)}));
    end else begin
      chk(v.own ? "R6" : "R4", "status unchanged", int'(mem[row]), int'(stat0));
      chk(v.own ? "R6" : "R4", "count unchanged", int'(mem[row + 1]), int'(cnt0));
    end
    if (v.kind != 2'd1) begin
      if (v.own) begin
        for (int k = 0; k < lim; k++)
          chk("R5", "buffer byte", int'(mem[11'(bufa + 11'(k))]), int'(pat(v.idx, k)));
      end
      chk(v.own ? "R6" : "R4", "no write past limit", int'(mem[11'(bufa + 11'(v.own ? lim : 0))]), 8'hEE);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog R10: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    vec_t a, b;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "hs in reset", int'(hs_valid), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "we in reset", int'(ram_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "we after reset", int'(ram_we), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2: second request while busy is dropped
    a = '{2'd1, 6'd40, 4'h9, 1'b1, 10'd20, 16'h0740, 11'd0};
    b = '{2'd1, 6'd41, 4'h9, 1'b1, 10'd30, 16'h0760, 11'd0};
    setup_bd(a);
    setup_bd(b);
    issue(a);
    @(negedge clk);
    req = 1'b1; req_idx = b.idx; req_pid = b.pid; req_kind = b.kind;
    @(negedge clk);
    req = 1'b0;
    wait_hs;
    chk("R2", "busy request ack", int'(hs_ack), 1);
    chk("R2", "index of first request", int'(done_idx), 40);
    @(negedge clk);
    chk("R2", "idle after first", int'(busy), 0);
    repeat (12) @(negedge clk);
    chk("R2", "no second transaction", int'(busy), 0);
    chk("R2", "second status untouched", int'(mem[11'd164]), int'({1'b1, 5'b01011, b.maxc[9:8]}));
    chk("R2", "second count untouched", int'(mem[11'd165]), int'(b.maxc[7:0]));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule